// File: doc/BRIEF.md
# Low-Power Mode Gate and Reset-Cause Controller

This block sits on a small processor's 16-bit register bus. It decides whether the core's requests for its two low-power modes (stop and wait) are allowed through. It also lets software ask for a device reset, and it keeps a record of which kind of reset brought the device up.

Two registers are mapped on the bus: a control register and a reset-cause register.

The control register holds one 2-bit gate field for each low-power mode, a debug-clock select bit and a self-clearing software-reset trigger bit. Each gate field has four encodings:

- Open: requests pass to the mode-entry output.
- Soft-blocked: requests are blocked, and the field can still be rewritten.
- Locked (two encodings): requests are blocked, and the field ignores every write until the next device reset.

The reset-cause register holds four sticky flags, one for each reset source. A reset other than power-on only adds its own flag and never removes flags that are already set. A power-on reset starts the register afresh. Software removes a flag by writing 1 to it.

The device reset is presented on `rst`, which is synchronous and active high, together with a 2-bit cause code on `rst_cause`. The cause is sampled on every clock edge where `rst` is high.

Top module: `sysctl_lpgate`

## Requirements
- R1: A single-cycle `core_stop_req` raises `stop_enter` for exactly one cycle on the following clock edge, only when the stop gate field (control bits 3:2) is 00 at the edge where the request is sampled.
- R2: Writing 01 to the stop gate field blocks `stop_enter`, and the field can still be rewritten afterwards, for example back to 00.
- R3: Once the stop gate field holds 10 or 11, writes to bits 3:2 are ignored and `stop_enter` stays low until the next reset of any kind.
- R4: The wait gate field (control bits 1:0) follows the same four encodings and the same locking rule, and it gates `core_wait_req` onto `wait_enter` with the same one-cycle timing.
- R5: A control write with bit 4 set drives `reset_req` high for exactly one cycle, on the edge after the write. Bit 4 always reads back as 0.
- R6: Control bit 5 is readable and writable. When it is 0, `dbg_clk_en` follows `tap_en`. When it is 1, `dbg_clk_en` is 1.
- R7: The reset-cause register is at address 1. It has the software-reset flag at bit 5, the watchdog flag at bit 4, the external flag at bit 3 and the power-on flag at bit 2. Its other bits read 0, and writes to them have no effect.
- R8: A reset with cause code 1 (external), 2 (watchdog) or 3 (software) sets the matching flag, leaves every other flag unchanged, and clears the control register to 0.
- R9: A reset with cause code 0 (power-on) clears the control register to 0 and leaves the reset-cause register reading exactly 0x0004.
- R10: Writing 1 to a flag position clears that flag. Writing 0 to a flag position leaves the flag unchanged.
- R11: `rdata` shows the addressed register in the same cycle that `rd_en` is high. It reads 0 when `rd_en` is low or the address is unmapped. The control register is at address 0, and control bits 15:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset |
| rst_cause | input | 2 | Reset cause code while `rst` is high: 0 power-on, 1 external, 2 watchdog, 3 software |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| core_stop_req | input | 1 | Core request to enter stop mode |
| core_wait_req | input | 1 | Core request to enter wait mode |
| tap_en | input | 1 | Debug port enabled |
| stop_enter | output | 1 | One-cycle stop-mode entry |
| wait_enter | output | 1 | One-cycle wait-mode entry |
| reset_req | output | 1 | One-cycle software reset request |
| dbg_clk_en | output | 1 | Debug clock enable to the core |

## Verification
The bench's corner cases, and what a faulty design would show for each:

- Rewriting a locked gate field, including with the other locking encoding and with 00. A design with a broken lock would read back the new value and would let a later mode request through.
- A soft-blocked field set back to 00. A design that locks on 01 would keep blocking, so the field would not read back as 00 and requests would not pass.
- A non-power-on reset after several flags are set. A design that overwrites the flags instead of accumulating them would lose the older causes. A design that keeps control state across reset would leave the gate fields locked.
- Status writes of 0. A design that follows a write-0-sets or toggle rule would change the flag pattern.
- The software-reset round trip. A design whose trigger bit is sticky or stored would stretch the pulse or read bit 4 back as 1.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int REG_W     = 16;
    localparam int N_MODES   = 2;
    localparam int MODE_WAIT = 0;
    localparam int MODE_STOP = 1;
    localparam int GATE_W    = 2;
    localparam int DBG_BIT   = 5;
    localparam int SWRST_BIT = 4;
    localparam int FLAG_LSB  = 2;
    localparam int N_FLAGS   = 4;

    typedef enum logic [1:0] {
        CAUSE_POR  = 2'd0,
        CAUSE_EXT  = 2'd1,
        CAUSE_WDOG = 2'd2,
        CAUSE_SW   = 2'd3
    } rst_cause_e;

    typedef enum logic [GATE_W-1:0] {
        GATE_OPEN     = 2'b00,
        GATE_SOFT     = 2'b01,
        GATE_LOCK     = 2'b10,
        GATE_LOCK_ALT = 2'b11
    } gate_e;

    typedef struct packed {
        logic  dbg_always;
        gate_e stop_g;
        gate_e wait_g;
    } ctrl_s;

    function automatic logic gate_passes(input gate_e g);
        return g == GATE_OPEN;
    endfunction

    function automatic logic gate_locked(input gate_e g);
        return g[1];
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_s c);
        logic [REG_W-1:0] r;
        r = '0;
        r[DBG_BIT] = c.dbg_always;
        r[GATE_W*MODE_STOP +: GATE_W] = c.stop_g;
        r[GATE_W*MODE_WAIT +: GATE_W] = c.wait_g;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input logic [N_FLAGS-1:0] f);
        logic [REG_W-1:0] r;
        r = '0;
        r[FLAG_LSB +: N_FLAGS] = f;
        return r;
    endfunction

endpackage

// File: rtl/sysctl_mode_gate.sv
module sysctl_mode_gate
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [GATE_W-1:0] wr_val,
    input  logic              req,
    output gate_e             field,
    output logic              enter
);

    always_ff @(posedge clk) begin
        if (rst) begin
            field <= GATE_OPEN;
            enter <= 1'b0;
        end else begin
            enter <= req && gate_passes(field);
            if (wr_en && !gate_locked(field)) begin
                field <= gate_e'(wr_val);
            end
        end
    end

endmodule

// File: rtl/sysctl_ctrl_reg.sv
module sysctl_ctrl_reg
    import sysctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wdata,
    input  logic [N_MODES-1:0] mode_req,
    output logic [N_MODES-1:0] mode_enter,
    output ctrl_s              ctrl,
    output logic               reset_req
);

    gate_e fld [N_MODES];
    logic  dbg_q;

    for (genvar m = 0; m < N_MODES; m++) begin : g_mode
        sysctl_mode_gate u_gate (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en),
            .wr_val (wdata[GATE_W*m +: GATE_W]),
            .req    (mode_req[m]),
            .field  (fld[m]),
            .enter  (mode_enter[m])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_q     <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            reset_req <= wr_en && wdata[SWRST_BIT];
            if (wr_en) begin
                dbg_q <= wdata[DBG_BIT];
            end
        end
    end

    always_comb begin
        ctrl.dbg_always = dbg_q;
        ctrl.stop_g     = fld[MODE_STOP];
        ctrl.wait_g     = fld[MODE_WAIT];
    end

endmodule

// File: rtl/sysctl_rst_status.sv
module sysctl_rst_status
    import sysctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  rst_cause_e         cause,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wdata,
    output logic [N_FLAGS-1:0] flags
);

    logic [N_FLAGS-1:0] cause_hot;

    always_comb begin
        cause_hot = '0;
        cause_hot[cause] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if (cause == CAUSE_POR) begin
                flags <= cause_hot;
            end else begin
                flags <= flags | cause_hot;
            end
        end else if (wr_en) begin
            flags <= flags & ~wdata[FLAG_LSB +: N_FLAGS];
        end
    end

endmodule

// File: rtl/sysctl_lpgate.sv
module sysctl_lpgate
    import sysctl_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int CTRL_OFS = 0,
    parameter int STAT_OFS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        rst_cause,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              core_stop_req,
    input  logic              core_wait_req,
    input  logic              tap_en,
    output logic              stop_enter,
    output logic              wait_enter,
    output logic              reset_req,
    output logic              dbg_clk_en
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic               sel_ctrl;
    logic               sel_stat;
    logic [N_MODES-1:0] mode_req;
    logic [N_MODES-1:0] mode_enter;
    ctrl_s              ctrl_q;
    logic [N_FLAGS-1:0] flags_q;

    assign sel_ctrl = (addr == CTRL_A);
    assign sel_stat = (addr == STAT_A);

    always_comb begin
        mode_req            = '0;
        mode_req[MODE_STOP] = core_stop_req;
        mode_req[MODE_WAIT] = core_wait_req;
    end

    sysctl_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en && sel_ctrl),
        .wdata      (wdata),
        .mode_req   (mode_req),
        .mode_enter (mode_enter),
        .ctrl       (ctrl_q),
        .reset_req  (reset_req)
    );

    sysctl_rst_status u_stat (
        .clk   (clk),
        .rst   (rst),
        .cause (rst_cause_e'(rst_cause)),
        .wr_en (wr_en && sel_stat),
        .wdata (wdata),
        .flags (flags_q)
    );

    assign stop_enter = mode_enter[MODE_STOP];
    assign wait_enter = mode_enter[MODE_WAIT];
    assign dbg_clk_en = ctrl_q.dbg_always | tap_en;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel_ctrl) begin
                rdata = pack_ctrl(ctrl_q);
            end else if (sel_stat) begin
                rdata = pack_status(flags_q);
            end
        end
    end

endmodule

// File: rtl/sysctl_lpgate_checker.sv
module sysctl_lpgate_checker #(
    parameter int ADDR_W   = 2,
    parameter int CTRL_OFS = 0,
    parameter int STAT_OFS = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        rst_cause,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [15:0]       wdata,
    input logic              core_stop_req,
    input logic              core_wait_req,
    input logic              stop_enter,
    input logic              wait_enter,
    input logic              reset_req,
    input logic [1:0]        stop_fld,
    input logic [1:0]        wait_fld,
    input logic [3:0]        flags
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    // R1: stop entry only follows a request seen while the gate was open
    p_stop_gate_r1: assert property (@(posedge clk) disable iff (rst)
        stop_enter |-> ($past(core_stop_req) && ($past(stop_fld) == 2'b00)));

    // R3: a locked stop field holds its value
    p_stop_lock_r3: assert property (@(posedge clk) disable iff (rst)
        stop_fld[1] |=> $stable(stop_fld));

    // R4: wait gating and locking
    p_wait_gate_r4: assert property (@(posedge clk) disable iff (rst)
        wait_enter |-> ($past(core_wait_req) && ($past(wait_fld) == 2'b00)));

    p_wait_lock_r4: assert property (@(posedge clk) disable iff (rst)
        wait_fld[1] |=> $stable(wait_fld));

    // R5: reset request comes only from a trigger write
    p_rst_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(wr_en && (addr == CTRL_A) && wdata[4]));

    // R9: power-on leaves only the power-on flag
    p_por_flags_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && ($past(rst_cause) == 2'd0)) |-> (flags == 4'b0001));

    // R10: a flag only drops on a write of 1 to its position
    for (genvar i = 0; i < 4; i++) begin : g_flag
        p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $fell(flags[i]))
                |-> $past(wr_en && (addr == STAT_A) && wdata[2+i]));
    end

endmodule

bind sysctl_lpgate sysctl_lpgate_checker #(
    .ADDR_W   (ADDR_W),
    .CTRL_OFS (CTRL_OFS),
    .STAT_OFS (STAT_OFS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rst_cause     (rst_cause),
    .addr          (addr),
    .wr_en         (wr_en),
    .wdata         (wdata),
    .core_stop_req (core_stop_req),
    .core_wait_req (core_wait_req),
    .stop_enter    (stop_enter),
    .wait_enter    (wait_enter),
    .reset_req     (reset_req),
    .stop_fld      (ctrl_q.stop_g),
    .wait_fld      (ctrl_q.wait_g),
    .flags         (flags_q)
);

// File: tb/sysctl_lpgate_bench.sv
module sysctl_lpgate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 150000;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  rst_cause = 2'd0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        core_stop_req = 1'b0;
    logic        core_wait_req = 1'b0;
    logic        tap_en = 1'b0;
    logic        stop_enter;
    logic        wait_enter;
    logic        reset_req;
    logic        dbg_clk_en;

    int errors = 0;
    int checks = 0;

    logic [1:0] m_stop = '0;
    logic [1:0] m_wait = '0;
    logic       m_dbg = 1'b0;
    logic [3:0] m_flags = 4'b0001;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_lpgate u_sysctl_lpgate (
        .clk           (clk),
        .rst           (rst),
        .rst_cause     (rst_cause),
        .addr          (addr),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .wdata         (wdata),
        .rdata         (rdata),
        .core_stop_req (core_stop_req),
        .core_wait_req (core_wait_req),
        .tap_en        (tap_en),
        .stop_enter    (stop_enter),
        .wait_enter    (wait_enter),
        .reset_req     (reset_req),
        .dbg_clk_en    (dbg_clk_en)
    );

    function automatic logic [15:0] exp_ctrl();
        return {10'b0, m_dbg, 1'b0, m_stop, m_wait};
    endfunction

    function automatic logic [15:0] exp_stat();
        return {10'b0, m_flags, 2'b0};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] c);
        @(negedge clk);
        rst = 1'b1;
        rst_cause = c;
        @(negedge clk);
        rst = 1'b0;
        m_stop = '0;
        m_wait = '0;
        m_dbg = 1'b0;
        if (c == 2'd0) m_flags = 4'b0001;
        else m_flags[c] = 1'b1;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        rd_en = 1'b1;
        #1;
        check(tag, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == A_CTRL) begin
            check("R5 pulse", {15'b0, reset_req}, {15'b0, d[4]});
            m_dbg = d[5];
            if (!m_stop[1]) m_stop = d[3:2];
            if (!m_wait[1]) m_wait = d[1:0];
            if (d[4]) begin
                @(negedge clk);
                check("R5 one cycle", {15'b0, reset_req}, 16'h0);
            end
        end else if (a == A_STAT) begin
            m_flags = m_flags & ~d[5:2];
        end
    endtask

    task automatic mode_req(input bit stop, input string tag);
        @(negedge clk);
        if (stop) core_stop_req = 1'b1;
        else core_wait_req = 1'b1;
        @(negedge clk);
        core_stop_req = 1'b0;
        core_wait_req = 1'b0;
        if (stop) begin
            check(tag, {14'b0, stop_enter, wait_enter}, {14'b0, m_stop == 2'b00, 1'b0});
        end else begin
            check(tag, {14'b0, stop_enter, wait_enter}, {15'b0, m_wait == 2'b00});
        end
        @(negedge clk);
        check({tag, " drop"}, {14'b0, stop_enter, wait_enter}, 16'h0);
    endtask

    task automatic dbg_chk(input logic t);
        @(negedge clk);
        tap_en = t;
        #1;
        check("R6 dbg_clk_en", {15'b0, dbg_clk_en}, {15'b0, m_dbg | t});
    endtask

    initial begin : watchdog
        repeat (WDOG_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        rst = 1'b1;
        rst_cause = 2'd0;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R9 power-on state
        rd_chk(A_CTRL, 16'h0000, "R9 ctrl after POR");
        rd_chk(A_STAT, 16'h0004, "R9 status after POR");
        // R11 strobe low and unmapped address
        @(negedge clk); addr = A_STAT; rd_en = 1'b0; #1;
        check("R11 rd_en low", rdata, 16'h0);
        rd_chk(2'd2, 16'h0, "R11 unmapped");

        // R1 open stop gate
        mode_req(1'b1, "R1 stop open");
        // R2 soft block then reopen
        wr_reg(A_CTRL, 16'h0004);
        mode_req(1'b1, "R2 stop soft blocked");
        wr_reg(A_CTRL, 16'h0000);
        rd_chk(A_CTRL, exp_ctrl(), "R2 rewritable");
        mode_req(1'b1, "R2 stop reopened");
        // R3 lock
        wr_reg(A_CTRL, 16'h0008);
        wr_reg(A_CTRL, 16'h0000);
        rd_chk(A_CTRL, 16'h0008, "R3 locked stays 10");
        wr_reg(A_CTRL, 16'h000C);
        rd_chk(A_CTRL, 16'h0008, "R3 locked ignores 11");
        mode_req(1'b1, "R3 stop locked");
        // R4 wait encodings
        mode_req(1'b0, "R4 wait open");
        wr_reg(A_CTRL, 16'h0001);
        mode_req(1'b0, "R4 wait soft");
        wr_reg(A_CTRL, 16'h0003);
        wr_reg(A_CTRL, 16'h0000);
        rd_chk(A_CTRL, 16'h000B, "R4 wait locked 11");
        mode_req(1'b0, "R4 wait locked");
        // R6 debug clock
        dbg_chk(1'b0);
        dbg_chk(1'b1);
        wr_reg(A_CTRL, 16'h0020);
        dbg_chk(1'b0);
        rd_chk(A_CTRL, exp_ctrl(), "R6 bit5 readback");
        // R11 upper control bits
        wr_reg(A_CTRL, 16'hFFC0);
        rd_chk(A_CTRL, exp_ctrl(), "R11 ctrl upper bits zero");
        // R8 external reset clears locks, keeps POR flag
        do_reset(2'd1);
        rd_chk(A_CTRL, 16'h0000, "R8 ctrl cleared");
        rd_chk(A_STAT, 16'h000C, "R8 ext added");
        mode_req(1'b1, "R8 stop reopened after reset");
        // R5 software reset round trip
        wr_reg(A_CTRL, 16'h0010);
        rd_chk(A_CTRL, 16'h0000, "R5 bit4 reads 0");
        do_reset(2'd3);
        rd_chk(A_STAT, 16'h002C, "R8 sw flag");
        do_reset(2'd2);
        rd_chk(A_STAT, 16'h003C, "R8 wdog flag");
        // R10 and R7 status writes
        wr_reg(A_STAT, 16'h0000);
        rd_chk(A_STAT, 16'h003C, "R10 write 0 no effect");
        wr_reg(A_STAT, 16'hFFC3);
        rd_chk(A_STAT, 16'h003C, "R7 reserved writes ignored");
        wr_reg(A_STAT, 16'h0028);
        rd_chk(A_STAT, 16'h0014, "R10 write 1 clears");
        // R9 POR wipes accumulated flags
        wr_reg(A_CTRL, 16'h002A);
        do_reset(2'd0);
        rd_chk(A_STAT, 16'h0004, "R9 POR flags");
        rd_chk(A_CTRL, 16'h0000, "R9 POR ctrl");

        // mixed random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [15:0] d;
            op = $urandom_range(0, 9);
            d = 16'($urandom);
            case (op)
                0, 1: begin
                    d[4] = ($urandom_range(0, 7) == 0);
                    wr_reg(A_CTRL, d);
                    if (d[4]) do_reset(2'd3);
                end
                2: wr_reg(A_STAT, d);
                3: rd_chk(A_CTRL, exp_ctrl(), "R3 random ctrl");
                4: rd_chk(A_STAT, exp_stat(), "R10 random status");
                5: mode_req(1'b1, "R1 random stop");
                6: mode_req(1'b0, "R4 random wait");
                7: dbg_chk(logic'($urandom_range(0, 1)));
                8: do_reset(2'($urandom_range(1, 3)));
                default: if ($urandom_range(0, 3) == 0) do_reset(2'd0);
                         else rd_chk(2'($urandom_range(2, 3)), 16'h0, "R11 random unmapped");
            endcase
        end
        rd_chk(A_STAT, exp_stat(), "R8 final status");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule